// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block drives the control lines of an 8080-style parallel display bus. It produces chip-select, write strobe, read strobe and the address/data select line (A0). One single-cycle request starts one access. An access is a command write, a data write or a read. Each strobe edge is placed at a programmable tick offset from the start of the access. The offsets come from two timing words. A granularity input sets each tick to one or two clocks.

During a write the block drives the accepted word onto the bus and raises the output enable. During a read it captures the input bus at a programmed access tick and presents the captured word with a one-clock valid pulse. Separate polarity bits invert each control line. A busy flag and a ready handshake hold off new requests until the current access has run its full length.

Top module: `pbusStrobeTop`

## Requirements
- R1: After reset the block is idle. busy and rdValid are 0, reqReady is 1, dataOe is 0, and every control line sits at its inactive level.
- R2: Ticks are counted from 0 in the first clock after a request is accepted. CS is active from tick csOn up to, but not including, the later of csOff and csOn+csPulse. The onOffTime word places csOn at [3:0] and csOff at [9:4]. The cycleTime word places the minimum CS pulse at [17:12].
- R3: On writes only, WE is active from tick weOn up to, but not including, weOff, with weOn at [13:10] and weOff at [19:14]. On reads only, RE is active from tick reOn up to, but not including, reOff, with reOn at [23:20] and reOff at [29:24]. WE and RE are never both active.
- R4: With tickX2=0 one tick lasts one clock. With tickX2=1 one tick lasts two clocks, so every edge falls at twice its tick count.
- R5: reqKind 0 is a command write, 1 is a data write, and 2 or 3 (bit 1 set) is a read. A0 is at level 0 for a command and at level 1 otherwise, before polarity is applied. A0 stays stable for the whole access, and it is at level 0 when idle.
- R6: Polarity bit 0 inverts A0, bit 1 inverts RE, bit 2 inverts WE and bit 3 inverts CS; a bit of 1 inverts its line. When idle every line equals its polarity bit and dataOe is 0.
- R7: On a read, dataIn is captured at the clock edge that ends the first clock of tick accessTime. rdValid is then 1 for exactly the following clock, with rdData holding the captured word.
- R8: An access lasts L ticks, where L is the larger of the cycle length for its kind and the CS end from R2. The write length sits at cycleTime [5:0] and the read length at [11:6]. busy is 1 for the L ticks, and reqReady is its inverse. A request raised while busy has no effect on the running access. It is accepted in the first clock after busy falls.
- R9: For the whole of a write access dataOe is 1 and dataOut holds the word accepted with the request. dataOe is 0 during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request, taken when reqReady is 1 |
| reqReady | output | 1 | Block can accept a request |
| reqKind | input | 2 | 0 command write, 1 data write, 2/3 read |
| reqData | input | DW | Word to drive on a write |
| onOffTime | input | 30 | Assert/deassert ticks for CS, WE, RE |
| cycleTime | input | 18 | Write length, read length, minimum CS pulse |
| accessTime | input | 6 | Read capture tick |
| tickX2 | input | 1 | 1: a tick lasts two clocks |
| polarity | input | 4 | Inversion bits for A0, RE, WE, CS |
| dataIn | input | DW | Bus input data for reads |
| dataOut | output | DW | Bus output data |
| dataOe | output | 1 | Bus output enable |
| csOut | output | 1 | Chip select |
| weOut | output | 1 | Write strobe |
| reOut | output | 1 | Read strobe |
| a0Out | output | 1 | Command/data select |
| rdData | output | DW | Captured read word |
| rdValid | output | 1 | One-clock pulse with rdData |
| busy | output | 1 | Access in progress |

## Verification
Two events can fall in the same clock. One is the end of an access. The other is a pending request, which may already be waiting on reqValid during the last tick. The bench provokes this by chaining accesses. It raises the next request throughout the running access. It then checks two things on every clock: that the running access keeps its own data, A0 level and length, and that the waiting request starts exactly one clock after busy falls. A read whose capture tick sits on the last tick of its access is also included. This places the rdValid pulse on the idle clock next to the handover, where it is checked.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  // request kinds; bit 1 set means read
  localparam logic [1:0] KIND_CMD  = 2'd0;
  localparam logic [1:0] KIND_DATA = 2'd1;
  localparam logic [1:0] KIND_READ = 2'd2;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;     // request accepted: restart tick count, latch kind and data
    logic step;     // advance to next tick
    logic finish;   // last clock of last tick
    logic capture;  // sample read data this clock
  } ctlStrobes_t;
endpackage

// File: rtl/pbusCtrl.sv
module pbusCtrl
  import pbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        tickX2,
  input  logic        atLastTick,
  input  logic        atAccessTick,
  output logic        reqReady,
  output logic        busy,
  output ctlStrobes_t ctl
);
  logic busyQ;
  logic subQ;      // second clock of a doubled tick
  logic tickEnd;

  assign busy     = busyQ;
  assign reqReady = !busyQ;
  assign tickEnd  = busyQ && (!tickX2 || subQ);

  always_comb begin
    ctl.load    = reqValid && !busyQ;
    ctl.step    = tickEnd && !atLastTick;
    ctl.finish  = tickEnd && atLastTick;
    ctl.capture = busyQ && atAccessTick && !subQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      subQ  <= 1'b0;
    end else begin
      if (ctl.load) begin
        busyQ <= 1'b1;
        subQ  <= 1'b0;
      end else if (ctl.finish) begin
        busyQ <= 1'b0;
        subQ  <= 1'b0;
      end else if (busyQ && tickX2) begin
        subQ <= !subQ;
      end else begin
        subQ <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pbusDatapath.sv
module pbusDatapath
  import pbus_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ON_W  = 4,
  parameter int OFF_W = 6,
  localparam int TW      = OFF_W + 1,
  localparam int ONOFF_W = 3 * (ON_W + OFF_W),
  localparam int CYC_W   = 3 * OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic               busy,
  input  logic [1:0]         reqKind,
  input  logic [DW-1:0]      reqData,
  input  logic [ONOFF_W-1:0] onOffTime,
  input  logic [CYC_W-1:0]   cycleTime,
  input  logic [OFF_W-1:0]   accessTime,
  input  logic [3:0]         polarity,
  input  logic [DW-1:0]      dataIn,
  output logic               atLastTick,
  output logic               atAccessTick,
  output logic [DW-1:0]      dataOut,
  output logic               dataOe,
  output logic               csOut,
  output logic               weOut,
  output logic               reOut,
  output logic               a0Out,
  output logic [DW-1:0]      rdData,
  output logic               rdValid
);
  localparam int P_CSON  = 0;
  localparam int P_CSOFF = ON_W;
  localparam int P_WEON  = ON_W + OFF_W;
  localparam int P_WEOFF = 2 * ON_W + OFF_W;
  localparam int P_REON  = 2 * ON_W + 2 * OFF_W;
  localparam int P_REOFF = 3 * ON_W + 2 * OFF_W;

  logic [TW-1:0] csOn, csOff, weOn, weOff, reOn, reOff;
  logic [TW-1:0] wrLen, rdLen, csPulse, accTick;
  logic [TW-1:0] csPulseEnd, csEnd, cycLen, accLen;
  logic [TW-1:0] tickQ;
  logic [1:0]    kindQ;
  logic [DW-1:0] dataQ;
  logic          isRead, isWrite;
  logic          csAct, weAct, reAct, a0Lvl;

  assign csOn    = TW'(onOffTime[P_CSON  +: ON_W]);
  assign csOff   = TW'(onOffTime[P_CSOFF +: OFF_W]);
  assign weOn    = TW'(onOffTime[P_WEON  +: ON_W]);
  assign weOff   = TW'(onOffTime[P_WEOFF +: OFF_W]);
  assign reOn    = TW'(onOffTime[P_REON  +: ON_W]);
  assign reOff   = TW'(onOffTime[P_REOFF +: OFF_W]);
  assign wrLen   = TW'(cycleTime[0 +: OFF_W]);
  assign rdLen   = TW'(cycleTime[OFF_W +: OFF_W]);
  assign csPulse = TW'(cycleTime[2*OFF_W +: OFF_W]);
  assign accTick = TW'(accessTime);

  assign isRead  = kindQ[1];
  assign isWrite = !kindQ[1];

  // CS end stretched to honour the minimum pulse width
  assign csPulseEnd = csOn + csPulse;
  assign csEnd      = (csPulseEnd > csOff) ? csPulseEnd : csOff;
  assign cycLen     = isRead ? rdLen : wrLen;
  assign accLen     = (csEnd > cycLen) ? csEnd : cycLen;

  assign atLastTick   = (tickQ == accLen - TW'(1));
  assign atAccessTick = isRead && (tickQ == accTick);

  assign csAct = busy && (tickQ >= csOn) && (tickQ < csEnd);
  assign weAct = busy && isWrite && (tickQ >= weOn) && (tickQ < weOff);
  assign reAct = busy && isRead && (tickQ >= reOn) && (tickQ < reOff);
  assign a0Lvl = busy && (kindQ != KIND_CMD);

  assign a0Out   = polarity[0] ^ a0Lvl;
  assign reOut   = polarity[1] ^ reAct;
  assign weOut   = polarity[2] ^ weAct;
  assign csOut   = polarity[3] ^ csAct;
  assign dataOe  = busy && isWrite;
  assign dataOut = dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickQ   <= '0;
      kindQ   <= KIND_CMD;
      dataQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (ctl.load) begin
        tickQ <= '0;
        kindQ <= reqKind;
        dataQ <= reqData;
      end else if (ctl.step) begin
        tickQ <= tickQ + TW'(1);
      end
      rdValid <= ctl.capture;
      if (ctl.capture) rdData <= dataIn;
    end
  end
endmodule

// File: rtl/pbusStrobeTop.sv
module pbusStrobeTop
  import pbus_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ON_W  = 4,
  parameter int OFF_W = 6,
  localparam int ONOFF_W = 3 * (ON_W + OFF_W),
  localparam int CYC_W   = 3 * OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [1:0]         reqKind,
  input  logic [DW-1:0]      reqData,
  input  logic [ONOFF_W-1:0] onOffTime,
  input  logic [CYC_W-1:0]   cycleTime,
  input  logic [OFF_W-1:0]   accessTime,
  input  logic               tickX2,
  input  logic [3:0]         polarity,
  input  logic [DW-1:0]      dataIn,
  output logic [DW-1:0]      dataOut,
  output logic               dataOe,
  output logic               csOut,
  output logic               weOut,
  output logic               reOut,
  output logic               a0Out,
  output logic [DW-1:0]      rdData,
  output logic               rdValid,
  output logic               busy
);
  ctlStrobes_t ctl;
  logic atLastTick, atAccessTick;

  pbusCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .tickX2(tickX2),
    .atLastTick(atLastTick), .atAccessTick(atAccessTick),
    .reqReady(reqReady), .busy(busy), .ctl(ctl)
  );

  pbusDatapath #(.DW(DW), .ON_W(ON_W), .OFF_W(OFF_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy),
    .reqKind(reqKind), .reqData(reqData),
    .onOffTime(onOffTime), .cycleTime(cycleTime), .accessTime(accessTime),
    .polarity(polarity), .dataIn(dataIn),
    .atLastTick(atLastTick), .atAccessTick(atAccessTick),
    .dataOut(dataOut), .dataOe(dataOe),
    .csOut(csOut), .weOut(weOut), .reOut(reOut), .a0Out(a0Out),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/pbusStrobeChk.sv
module pbusStrobeChk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          busy,
  input logic          csOut,
  input logic          weOut,
  input logic          reOut,
  input logic          a0Out,
  input logic          dataOe,
  input logic [DW-1:0] dataOut,
  input logic          rdValid,
  input logic [3:0]    polarity
);
  // R6: idle lines rest at their polarity levels, bus not driven
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csOut == polarity[3] && weOut == polarity[2] &&
               reOut == polarity[1] && !dataOe));

  // R3: write and read strobes never active together
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !((weOut ^ polarity[2]) && (reOut ^ polarity[1])));

  // R5: A0 holds through an access
  a_r5_a0_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $stable(polarity)) |-> $stable(a0Out));

  // R8: an accepted request makes the block busy next clock
  a_r8_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  // R9: bus output only during an access, data steady while driven
  a_r9_oe_in_access: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> busy);
  a_r9_data_steady: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe)) |-> $stable(dataOut));

  // R7: read valid only follows a busy clock
  a_r7_valid_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(busy));
endmodule

bind pbusStrobeTop pbusStrobeChk #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busy(busy), .csOut(csOut), .weOut(weOut), .reOut(reOut), .a0Out(a0Out),
  .dataOe(dataOe), .dataOut(dataOut), .rdValid(rdValid), .polarity(polarity)
);

// File: tb/tb_pbusStrobeTop.sv
module tb_pbusStrobeTop;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqKind = 2'd0;
  logic [DW-1:0] reqData = '0;
  logic [29:0]   onOffTime = '0;
  logic [17:0]   cycleTime = '0;
  logic [5:0]    accessTime = '0;
  logic          tickX2 = 1'b0;
  logic [3:0]    polarity = 4'h0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut, rdData;
  logic          dataOe, csOut, weOut, reOut, a0Out, rdValid, busy;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit pending = 0;

  // current timing (bench copy)
  int tCsOn, tCsOff, tWeOn, tWeOff, tReOn, tReOff, tWr, tRd, tPw, tAcc;

  pbusStrobeTop #(.DW(DW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqData(reqData), .onOffTime(onOffTime),
    .cycleTime(cycleTime), .accessTime(accessTime), .tickX2(tickX2),
    .polarity(polarity), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .csOut(csOut), .weOut(weOut), .reOut(reOut), .a0Out(a0Out),
    .rdData(rdData), .rdValid(rdValid), .busy(busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'(8'h3C + k * 7);
  endfunction

  task automatic setCfg(int csOn, int csOff, int weOn, int weOff, int reOn,
                        int reOff, int wr, int rd, int pw, int acc);
    tCsOn = csOn; tCsOff = csOff; tWeOn = weOn; tWeOff = weOff;
    tReOn = reOn; tReOff = reOff; tWr = wr; tRd = rd; tPw = pw; tAcc = acc;
    onOffTime  = {6'(reOff), 4'(reOn), 6'(weOff), 4'(weOn), 6'(csOff), 4'(csOn)};
    cycleTime  = {6'(pw), 6'(rd), 6'(wr)};
    accessTime = 6'(acc);
  endtask

  task automatic checkIdle(string req);
    chk(req, "busy", busy, 0);
    chk(req, "ready", reqReady, 1);
    chk(req, "cs", csOut, polarity[3]);
    chk(req, "we", weOut, polarity[2]);
    chk(req, "re", reOut, polarity[1]);
    chk(req, "a0", a0Out, polarity[0]);
    chk(req, "oe", dataOe, 0);
  endtask

  // one access; if chain, the next request is held on the bus during this one
  task automatic doAccess(int kind, logic [7:0] data, bit chain,
                          int nKind, logic [7:0] nData);
    int p, csEnd, len, t;
    bit rd, wr, csA, weA, reA, bz;
    string tr;
    p = tickX2 ? 2 : 1;
    tr = tickX2 ? "R4" : "R2";
    rd = (kind >= 2);
    wr = !rd;
    csEnd = (tCsOn + tPw > tCsOff) ? tCsOn + tPw : tCsOff;
    len = rd ? tRd : tWr;
    if (csEnd > len) len = csEnd;
    if (!pending) begin
      @(negedge clk);
      reqValid = 1'b1; reqKind = 2'(kind); reqData = data;
    end
    pending = 0;
    @(posedge clk);
    for (int k = 0; k <= len * p; k++) begin
      @(negedge clk);
      t = k / p;
      bz = (k < len * p);
      csA = bz && t >= tCsOn && t < csEnd;
      weA = bz && wr && t >= tWeOn && t < tWeOff;
      reA = bz && rd && t >= tReOn && t < tReOff;
      chk("R8", "busy", busy, bz);
      chk("R8", "ready", reqReady, !bz);
      chk(tr, "cs", csOut, polarity[3] ^ csA);
      chk(tickX2 ? "R4" : "R3", "we", weOut, polarity[2] ^ weA);
      chk(tickX2 ? "R4" : "R3", "re", reOut, polarity[1] ^ reA);
      chk("R5", "a0", a0Out, polarity[0] ^ (bz && kind != 0));
      chk("R9", "oe", dataOe, bz && wr);
      if (bz && wr) chk("R9", "dataOut", dataOut, data);
      chk("R7", "rdValid", rdValid, rd && (k == tAcc * p + 1));
      if (rd && k == tAcc * p + 1) chk("R7", "rdData", rdData, pat(tAcc * p));
      if (!bz) checkIdle("R6");
      // drive after sampling
      dataIn = pat(k);
      if (chain) begin
        reqValid = 1'b1; reqKind = 2'(nKind); reqData = nData;
      end else begin
        reqValid = 1'b0; reqKind = 2'(3 - kind); reqData = ~data;
      end
    end
    pending = chain;
  endtask

  initial begin
    // R1: reset state
    #23;
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "ready", reqReady, 1);
    chk("R1", "rdValid", rdValid, 0);
    chk("R1", "oe", dataOe, 0);
    chk("R1", "cs", csOut, 0);
    chk("R1", "we", weOut, 0);
    chk("R1", "re", reOut, 0);
    chk("R1", "a0", a0Out, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");

    for (int s = 0; s < 4; s++) begin
      for (int g = 0; g < 2; g++) begin
        for (int q = 0; q < 3; q++) begin
          @(negedge clk);
          case (s)
            0: setCfg(0, 5, 1, 4, 1, 5, 5, 6, 3, 3);
            1: setCfg(2, 9, 3, 7, 2, 8, 8, 10, 9, 6);
            2: setCfg(0, 2, 0, 1, 0, 2, 2, 2, 0, 1);
            default: setCfg(15, 63, 15, 63, 15, 63, 63, 63, 63, 62);
          endcase
          tickX2 = 1'(g);
          polarity = (q == 0) ? 4'h0 : (q == 1) ? 4'hF : 4'h5;
          @(negedge clk);
          checkIdle("R6");
          // chained: command, data write, read; then a lone write
          doAccess(0, 8'h2C, 1, 1, 8'hA5);
          doAccess(1, 8'hA5, 1, 2, 8'h00);
          doAccess(2, 8'h00, 0, 0, 8'h00);
          doAccess(1, 8'(8'h11 * (s + 1)), 0, 0, 8'h00);
          doAccess(3, 8'h00, 0, 0, 8'h00);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule